// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when a backup battery is put under load and whether it is judged weak. It counts seconds from a one-second timebase tick. While main power is healthy and the power supervisor reports that its recovery delay is over, the block runs a load test each time a long interval ends. It also runs a test every time power returns. During a test it drives a load-enable output for a fixed number of ticks. On each tick of that window it samples a comparator flag that reports a low battery.

A failed test sets a battery-warning output. That output is sticky. A later periodic test that passes leaves it set. Only a test that passes right after power returns clears it. When power fails, any running test is aborted and the interval count is discarded. The warning is left as it was. Both interval lengths are parameters, so a bench can scale a day down to a few ticks.

Top module: `batt_health_mon`

## Requirements
- R1: After reset, `load_en`, `test_busy` and `batt_warn` are 0.
- R2: The block treats power as "up" when `pwr_good` and `recov_done` are both 1. On the first clock edge that samples power up after it was down (or after reset), a power-up test starts. `load_en` is 1 from the following cycle. It falls at the clock edge that samples the TEST_SEC-th `sec_tick` of the window.
- R3: A test fails if `batt_low` is 1 on any `sec_tick` sampled inside the window, including the final one. A failed test sets `batt_warn` to 1 at the edge where the window ends.
- R4: A power-up test that passes clears `batt_warn` to 0.
- R5: After a test ends, the next periodic test starts at the edge that samples the PERIOD_SEC-th `sec_tick`, counted from the end of that test. After PERIOD_SEC-1 ticks no test has started.
- R6: A periodic test that passes leaves `batt_warn` unchanged, so a set warning stays set.
- R7: While power is down, no test starts and no ticks are counted toward the interval. This holds when `recov_done` is 0 with `pwr_good` at 1.
- R8: A power failure during a test drops `load_en` in the next cycle and leaves `batt_warn` unchanged. The interval count is discarded, so the next test is a power-up test.
- R9: `test_busy` equals `load_en` in every cycle.
- R10: `batt_warn` changes only at the edge where a test window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| pwr_good | input | 1 | Main supply above its trip point |
| recov_done | input | 1 | Supervisor recovery delay has elapsed |
| batt_low | input | 1 | Comparator: battery below trip level under load |
| load_en | output | 1 | Connect the test load to the battery |
| batt_warn | output | 1 | Sticky battery warning |
| test_busy | output | 1 | A test window is in progress |

## Verification
A table walks successive power cycles. It sets the low flag only on the first tick of the window, only on the last tick, on both, or on neither. This catches a design that samples only one tick, or that fails to clear the warning after a power-up test that passes. Directed cases count ticks to one short of the interval and then to the full interval, which exposes off-by-one errors in the interval counter. A periodic test that passes must keep a set warning, so a design that clears the warning on every pass is caught. A power loss in mid-window must abort the test without touching the warning, and the cases with recovery still pending must show no test at all.

// File: rtl/bhm_pkg.sv
package bhm_pkg;
   typedef enum logic {
      BHM_IDLE = 1'b0,
      BHM_TEST = 1'b1
   } bhm_state_t;

   typedef enum logic {
      BHM_KIND_PERIODIC = 1'b0,
      BHM_KIND_POWERUP  = 1'b1
   } bhm_kind_t;
endpackage

// File: rtl/bhm_interval_timer.sv
module bhm_interval_timer #(
   parameter int unsigned PERIOD_SEC = 86400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic count_en,
   output logic expire
);
   localparam int unsigned CW = (PERIOD_SEC > 1) ? $clog2(PERIOD_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD_SEC - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (PERIOD_SEC < 2) begin : g_bad_period
         $error("bhm_interval_timer: PERIOD_SEC must be at least 2");
      end
   endgenerate

   assign expire = count_en && !clear && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || expire) begin
         cnt_q <= '0;
      end else if (count_en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bhm_test_window.sv
module bhm_test_window #(
   parameter int unsigned TEST_SEC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic tick,
   input  logic low,
   output logic load_en,
   output logic done,
   output logic failed
);
   logic active_q;
   logic fail_q;
   logic last_tick;

   generate
      if (TEST_SEC < 1) begin : g_bad_window
         $error("bhm_test_window: TEST_SEC must be at least 1");
      end
      if (TEST_SEC == 1) begin : g_single
         assign last_tick = 1'b1;
      end else begin : g_multi
         localparam int unsigned WW = $clog2(TEST_SEC);
         localparam logic [WW-1:0] WLAST = WW'(TEST_SEC - 1);
         logic [WW-1:0] wcnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wcnt_q <= '0;
            end else if (start || abort || !active_q) begin
               wcnt_q <= '0;
            end else if (tick) begin
               wcnt_q <= (wcnt_q == WLAST) ? '0 : wcnt_q + 1'b1;
            end
         end
         assign last_tick = (wcnt_q == WLAST);
      end
   endgenerate

   assign done    = active_q && !abort && tick && last_tick;
   assign failed  = fail_q || (tick && low);
   assign load_en = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         fail_q   <= 1'b0;
      end else if (abort) begin
         active_q <= 1'b0;
         fail_q   <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         fail_q   <= 1'b0;
      end else if (done) begin
         active_q <= 1'b0;
         fail_q   <= 1'b0;
      end else if (active_q && tick && low) begin
         fail_q   <= 1'b1;
      end
   end
endmodule

// File: rtl/bhm_warn_latch.sv
module bhm_warn_latch
   import bhm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      done,
   input  logic      failed,
   input  bhm_kind_t kind,
   output logic      warn
);
   logic warn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         warn_q <= 1'b0;
      end else if (done) begin
         if (failed) begin
            warn_q <= 1'b1;
         end else if (kind == BHM_KIND_POWERUP) begin
            warn_q <= 1'b0;
         end
      end
   end

   assign warn = warn_q;
endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon
   import bhm_pkg::*;
#(
   parameter int unsigned PERIOD_SEC = 86400,
   parameter int unsigned TEST_SEC   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic pwr_good,
   input  logic recov_done,
   input  logic batt_low,
   output logic load_en,
   output logic batt_warn,
   output logic test_busy
);
   logic       armed;
   logic       armed_q;
   logic       pwrup;
   logic       expire;
   logic       start;
   logic       done;
   logic       failed;
   logic       ivl_clear;
   logic       ivl_count;
   bhm_state_t state_q;
   bhm_kind_t  kind_q;

   assign armed     = pwr_good && recov_done;
   assign pwrup     = armed && !armed_q;
   assign ivl_clear = !armed || pwrup || (state_q == BHM_TEST);
   assign ivl_count = armed && sec_tick && (state_q == BHM_IDLE);
   assign start     = armed && (state_q == BHM_IDLE) && (pwrup || expire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         state_q <= BHM_IDLE;
         kind_q  <= BHM_KIND_PERIODIC;
      end else begin
         armed_q <= armed;
         if (!armed) begin
            state_q <= BHM_IDLE;
         end else if (start) begin
            state_q <= BHM_TEST;
            kind_q  <= pwrup ? BHM_KIND_POWERUP : BHM_KIND_PERIODIC;
         end else if (done) begin
            state_q <= BHM_IDLE;
         end
      end
   end

   bhm_interval_timer #(.PERIOD_SEC(PERIOD_SEC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ivl_clear),
      .count_en (ivl_count),
      .expire   (expire)
   );

   bhm_test_window #(.TEST_SEC(TEST_SEC)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .abort   (!armed),
      .tick    (sec_tick),
      .low     (batt_low),
      .load_en (load_en),
      .done    (done),
      .failed  (failed)
   );

   bhm_warn_latch u_warn (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (done),
      .failed (failed),
      .kind   (kind_q),
      .warn   (batt_warn)
   );

   assign test_busy = (state_q == BHM_TEST);
endmodule

// File: rtl/batt_health_mon_chk.sv
module batt_health_mon_chk (
   input logic clk,
   input logic rst_n,
   input logic sec_tick,
   input logic pwr_good,
   input logic recov_done,
   input logic load_en,
   input logic batt_warn,
   input logic test_busy
);
   assert_busy_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      test_busy == load_en);

   assert_no_load_unpowered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_good && recov_done) |=> !load_en);

   assert_warn_only_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (batt_warn != $past(batt_warn)) |-> ($past(load_en) && !load_en));

   assert_abort_keeps_warn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load_en) && !$past(pwr_good && recov_done)) |-> $stable(batt_warn));

   assert_window_ends_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_en) |-> ($past(sec_tick) || !$past(pwr_good && recov_done)));
endmodule

bind batt_health_mon batt_health_mon_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_tick   (sec_tick),
   .pwr_good   (pwr_good),
   .recov_done (recov_done),
   .load_en    (load_en),
   .batt_warn  (batt_warn),
   .test_busy  (test_busy)
);

// File: tb/batt_health_mon_bench.sv
module batt_health_mon_bench;
   localparam int unsigned P_PERIOD = 4;
   localparam int unsigned P_TEST   = 2;
   // {low on first tick, low on last tick, expected warn after power-up test}
   localparam logic [2:0] VEC [6] = '{3'b000, 3'b101, 3'b000, 3'b011, 3'b111, 3'b000};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_tick = 1'b0;
   logic pwr_good = 1'b0;
   logic recov_done = 1'b0;
   logic batt_low = 1'b0;
   logic load_en, batt_warn, test_busy;
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   batt_health_mon #(.PERIOD_SEC(P_PERIOD), .TEST_SEC(P_TEST)) u_batt_health_mon (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pwr_good(pwr_good),
      .recov_done(recov_done), .batt_low(batt_low), .load_en(load_en),
      .batt_warn(batt_warn), .test_busy(test_busy)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
      if (test_busy !== load_en) begin
         failures++;
         $display("FAIL R9 actual=%0b expected=%0b", test_busy, load_en);
      end
   endtask

   task automatic tick(input logic low);
      sec_tick = 1'b1; batt_low = low;
      @(negedge clk);
      sec_tick = 1'b0; batt_low = 1'b0;
      @(negedge clk);
   endtask

   task automatic power(input logic pg, input logic rd);
      pwr_good = pg; recov_done = rd;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 load_en", load_en, 1'b0);
      check("R1 warn", batt_warn, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table: one power-up test per entry
      foreach (VEC[i]) begin
         power(1'b0, 1'b0);
         power(1'b1, 1'b1);
         check("R2 load_en on power-up", load_en, 1'b1);
         tick(VEC[i][2]);
         check("R2 window still open", load_en, 1'b1);
         tick(VEC[i][1]);
         check("R2 window closed", load_en, 1'b0);
         check(VEC[i][0] ? "R3 warn after low tick" : "R4 warn after pass", batt_warn, VEC[i][0]);
      end

      // R7: recovery pending, no test, no counting
      power(1'b0, 1'b0);
      power(1'b1, 1'b0);
      for (int k = 0; k < 6; k++) tick(1'b0);
      check("R7 no test while recovery pending", load_en, 1'b0);

      // Power-up test fails -> warn set
      power(1'b1, 1'b1);
      check("R2 power-up start", load_en, 1'b1);
      tick(1'b1); tick(1'b0);
      check("R3 warn set", batt_warn, 1'b1);

      // R5 interval
      for (int k = 0; k < P_PERIOD - 1; k++) tick(1'b0);
      check("R5 no test before interval", load_en, 1'b0);
      tick(1'b0);
      check("R5 periodic test started", load_en, 1'b1);
      tick(1'b0); tick(1'b0);
      check("R5 periodic test ended", load_en, 1'b0);
      check("R6 periodic pass keeps warn", batt_warn, 1'b1);

      // Power cycle to clear, then abort a periodic test
      power(1'b0, 1'b0);
      power(1'b1, 1'b1);
      tick(1'b0); tick(1'b0);
      check("R4 cleared", batt_warn, 1'b0);
      for (int k = 0; k < P_PERIOD; k++) tick(1'b0);
      check("R5 second periodic start", load_en, 1'b1);
      tick(1'b1);
      power(1'b0, 1'b1);
      check("R8 load drops on power loss", load_en, 1'b0);
      check("R8 warn unchanged on abort", batt_warn, 1'b0);

      // R8: count discarded; partial interval then power loss
      power(1'b1, 1'b1);
      tick(1'b0); tick(1'b0);
      check("R4 pass after abort", batt_warn, 1'b0);
      tick(1'b0); tick(1'b0);
      power(1'b0, 1'b1);
      power(1'b1, 1'b1);
      check("R8 power-up test after loss", load_en, 1'b1);
      tick(1'b0); tick(1'b0);
      for (int k = 0; k < P_PERIOD - 1; k++) tick(1'b0);
      check("R8 interval restarted", load_en, 1'b0);
      tick(1'b0);
      check("R5 test after full interval", load_en, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule